// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block controls a port of eight pins through a small 16-bit register bus. For each pin it decides where the output and output enable come from. In GPIO mode they come from the block's own data and direction registers. In peripheral mode they come from one of four peripheral sources, chosen by a 2-bit selector for that pin.

On the input side, each pin is first synchronised by two flops. It can then pass through a debounce filter. That conditioned level feeds an edge detector, and the polarity of the detector is set per pin. A detected edge sets a sticky flag. Software clears a flag by writing a one to it. The flags are gated by per-pin enables and merged into a single level interrupt request.

A flag is set whether or not its pin's interrupt is enabled. Software can therefore clear a stale flag first and enable the pin afterwards, with no spurious request.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register field reads zero, pad_out and pad_oe are zero, and irq is low.
- R2: The register map is as follows:
  - address 0 holds the output data in bits 7:0;
  - address 1 holds the direction (1 = drive) in bits 7:0;
  - address 2 holds the falling-edge selects in bits 15:8 and the interrupt enables in bits 7:0;
  - address 3 holds the filter enables in bits 7:0;
  - address 4 holds the mode selects in bits 7:0 (1 = peripheral);
  - address 5 holds the function selectors;
  - address 6 holds the flags;
  - address 7 holds the conditioned input levels.
  - Unused upper bits read zero. Reads are combinational on bus_addr.
- R3: A pin's flag is set by a rising edge of its conditioned level when its edge-select bit is 0, and by a falling edge when the bit is 1. This happens independently of the pin's interrupt enable.
- R4: With the filter bypassed, a change on pad_in appears in the level register after two clock edges. It sets the flag on the third edge.
- R5: With the filter enabled, the conditioned level takes a new value only after the synchronised input has differed from it on 4 consecutive clock edges. A pulse of 3 cycles leaves the level and the flags unchanged.
- R6: Writing 1 to a bit at address 6 clears that flag, and writing 0 leaves it unchanged. When an edge and a clear of the same flag fall in one cycle, the flag stays set.
- R7: irq is high exactly when some pin has both its flag and its enable set. It stays high until software clears the flag or the enable.
- R8: With a pin's mode bit at 0, its pad_out and pad_oe equal its data and direction register bits.
- R9: With a pin's mode bit at 1, the selector in bits [2n+1:2n] of address 5 picks function f for pin n. pad_out[n] is then alt_out[f*8+n], and pad_oe[n] is alt_oe[f*8+n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| alt_out | input | 32 | Peripheral outputs, function f at bits f*8+7:f*8 |
| alt_oe | input | 32 | Peripheral output enables, same layout |
| irq | output | 1 | Combined level interrupt request |

## Verification
The inputs are driven with the following patterns:
- single steps, which fix the synchroniser latency;
- rising and falling transitions under both edge polarities, which show that polarity selects the edge;
- filtered pulses of three and four cycles, which separate the ignore and accept sides of the debounce limit;
- a flag clear that lands on the same edge as a new event, which shows that the set wins.

The output routing is tried with mixed per-pin selectors and then with a uniform selector. This shows that each pin decodes its own field.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_DOUT   = 3'd0,
      REG_DIR    = 3'd1,
      REG_EDGEIE = 3'd2,
      REG_FILT   = 3'd3,
      REG_MODE   = 3'd4,
      REG_FSEL   = 3'd5,
      REG_FLAG   = 3'd6,
      REG_LEVEL  = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
   parameter int N_PINS   = 8,
   parameter int FILT_CNT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pad_in,
   input  logic [N_PINS-1:0] filt_en,
   output logic [N_PINS-1:0] sync_lvl,
   output logic [N_PINS-1:0] filt_lvl,
   output logic [N_PINS-1:0] cond_lvl
);
   localparam int CNT_W = (FILT_CNT > 1) ? $clog2(FILT_CNT) : 1;

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      logic meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
         end else begin
            meta_q <= pad_in[i];
            sync_q <= meta_q;
         end
      end
      assign sync_lvl[i] = sync_q;

      if (FILT_CNT < 2) begin : g_direct
         assign filt_lvl[i] = sync_q;
      end else begin : g_count
         logic [CNT_W-1:0] run_q;
         logic             held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               held_q <= 1'b0;
            end else if (sync_q == held_q) begin
               run_q <= '0;
            end else if (run_q == CNT_W'(FILT_CNT - 1)) begin
               held_q <= sync_q;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign filt_lvl[i] = held_q;
      end
   end

   assign cond_lvl = (filt_en & filt_lvl) | (~filt_en & sync_lvl);
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
   parameter int N_PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] lvl,
   input  logic [N_PINS-1:0] fall_sel,
   input  logic [N_PINS-1:0] clr_mask,
   output logic [N_PINS-1:0] evt,
   output logic [N_PINS-1:0] flags
);
   logic [N_PINS-1:0] prev_q;
   logic [N_PINS-1:0] rise, fall;

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
   assign evt  = (fall_sel & fall) | (~fall_sel & rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flags  <= '0;
      end else begin
         prev_q <= lvl;
         flags  <= (flags & ~clr_mask) | evt;
      end
   end
endmodule

// File: rtl/gpio_out_route.sv
module gpio_out_route #(
   parameter int N_PINS = 8,
   parameter int FUNCS  = 4
) (
   input  logic [N_PINS-1:0]                  mode_sel,
   input  logic [N_PINS*$clog2(FUNCS)-1:0]    fsel,
   input  logic [N_PINS-1:0]                  dout,
   input  logic [N_PINS-1:0]                  dir,
   input  logic [FUNCS*N_PINS-1:0]            alt_out,
   input  logic [FUNCS*N_PINS-1:0]            alt_oe,
   output logic [N_PINS-1:0]                  pad_out,
   output logic [N_PINS-1:0]                  pad_oe
);
   localparam int FSEL_W = $clog2(FUNCS);

   for (genvar n = 0; n < N_PINS; n++) begin : g_pin
      logic [FSEL_W-1:0] f;
      logic              a_o, a_e;
      assign f = fsel[n*FSEL_W +: FSEL_W];
      always_comb begin
         a_o = 1'b0;
         a_e = 1'b0;
         for (int k = 0; k < FUNCS; k++) begin
            if (f == FSEL_W'(k)) begin
               a_o = alt_out[k*N_PINS + n];
               a_e = alt_oe[k*N_PINS + n];
            end
         end
      end
      assign pad_out[n] = mode_sel[n] ? a_o : dout[n];
      assign pad_oe[n]  = mode_sel[n] ? a_e : dir[n];
   end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_port_pkg::*;
#(
   parameter int N_PINS   = 8,
   parameter int DATA_W   = 16,
   parameter int FUNCS    = 4,
   parameter int FILT_CNT = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [N_PINS-1:0]       pad_in,
   output logic [N_PINS-1:0]       pad_out,
   output logic [N_PINS-1:0]       pad_oe,
   input  logic [FUNCS*N_PINS-1:0] alt_out,
   input  logic [FUNCS*N_PINS-1:0] alt_oe,
   output logic                    irq
);
   localparam int FSEL_W = $clog2(FUNCS);
   localparam int HALF   = DATA_W / 2;
   localparam int FS_BITS = N_PINS * FSEL_W;

   if (N_PINS > HALF) begin : g_bad_pins
      $error("N_PINS must fit in half the data width");
   end
   if (FS_BITS > DATA_W) begin : g_bad_fsel
      $error("function selectors must fit in one register");
   end
   if (FUNCS < 2) begin : g_bad_funcs
      $error("FUNCS must be at least 2");
   end

   logic [N_PINS-1:0]  r_dout, r_dir, r_edge, r_ie, r_fen, r_mode;
   logic [FS_BITS-1:0] r_fsel;
   logic [N_PINS-1:0]  sync_lvl, filt_lvl, cond_lvl;
   logic [N_PINS-1:0]  evt, flags, clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_dout <= '0;
         r_dir  <= '0;
         r_edge <= '0;
         r_ie   <= '0;
         r_fen  <= '0;
         r_mode <= '0;
         r_fsel <= '0;
      end else if (bus_wr) begin
         case (reg_sel_e'(bus_addr))
            REG_DOUT:   r_dout <= bus_wdata[N_PINS-1:0];
            REG_DIR:    r_dir  <= bus_wdata[N_PINS-1:0];
            REG_EDGEIE: begin
               r_edge <= bus_wdata[HALF +: N_PINS];
               r_ie   <= bus_wdata[N_PINS-1:0];
            end
            REG_FILT:   r_fen  <= bus_wdata[N_PINS-1:0];
            REG_MODE:   r_mode <= bus_wdata[N_PINS-1:0];
            REG_FSEL:   r_fsel <= bus_wdata[FS_BITS-1:0];
            default: ;
         endcase
      end
   end

   assign clr_mask = (bus_wr && reg_sel_e'(bus_addr) == REG_FLAG)
                     ? bus_wdata[N_PINS-1:0] : '0;

   gpio_in_cond #(.N_PINS(N_PINS), .FILT_CNT(FILT_CNT)) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .filt_en  (r_fen),
      .sync_lvl (sync_lvl),
      .filt_lvl (filt_lvl),
      .cond_lvl (cond_lvl)
   );

   gpio_edge_flags #(.N_PINS(N_PINS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (cond_lvl),
      .fall_sel (r_edge),
      .clr_mask (clr_mask),
      .evt      (evt),
      .flags    (flags)
   );

   gpio_out_route #(.N_PINS(N_PINS), .FUNCS(FUNCS)) u_route (
      .mode_sel (r_mode),
      .fsel     (r_fsel),
      .dout     (r_dout),
      .dir      (r_dir),
      .alt_out  (alt_out),
      .alt_oe   (alt_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   always_comb begin
      bus_rdata = '0;
      case (reg_sel_e'(bus_addr))
         REG_DOUT:   bus_rdata[N_PINS-1:0] = r_dout;
         REG_DIR:    bus_rdata[N_PINS-1:0] = r_dir;
         REG_EDGEIE: begin
            bus_rdata[HALF +: N_PINS] = r_edge;
            bus_rdata[N_PINS-1:0]     = r_ie;
         end
         REG_FILT:   bus_rdata[N_PINS-1:0] = r_fen;
         REG_MODE:   bus_rdata[N_PINS-1:0] = r_mode;
         REG_FSEL:   bus_rdata[FS_BITS-1:0] = r_fsel;
         REG_FLAG:   bus_rdata[N_PINS-1:0] = flags;
         REG_LEVEL:  bus_rdata[N_PINS-1:0] = cond_lvl;
         default: ;
      endcase
   end

   assign irq = |(flags & r_ie);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
   import gpio_port_pkg::*;
#(
   parameter int N_PINS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [N_PINS-1:0] wdata_lo,
   input logic              irq,
   input logic [N_PINS-1:0] pad_out,
   input logic [N_PINS-1:0] pad_oe,
   input logic [N_PINS-1:0] mode_sel,
   input logic [N_PINS-1:0] dout,
   input logic [N_PINS-1:0] dir,
   input logic [N_PINS-1:0] evt,
   input logic [N_PINS-1:0] flags,
   input logic [N_PINS-1:0] sync_lvl,
   input logic [N_PINS-1:0] filt_lvl
);
   logic sw_touch;
   assign sw_touch = bus_wr && (reg_sel_e'(bus_addr) == REG_FLAG ||
                                reg_sel_e'(bus_addr) == REG_EDGEIE);

   assert_event_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

   assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && reg_sel_e'(bus_addr) == REG_FLAG)
      |=> ((flags & $past(wdata_lo) & ~$past(evt)) == '0));

   assert_irq_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !sw_touch) |=> irq);

   assert_gpio_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == '0) |-> (pad_out == dout && pad_oe == dir));

   assert_filter_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((filt_lvl ^ $past(filt_lvl)) & ($past(sync_lvl) ^ filt_lvl)) == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.N_PINS(N_PINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wdata_lo (bus_wdata[N_PINS-1:0]),
   .irq      (irq),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .mode_sel (r_mode),
   .dout     (r_dout),
   .dir      (r_dir),
   .evt      (evt),
   .flags    (flags),
   .sync_lvl (sync_lvl),
   .filt_lvl (filt_lvl)
);

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/100ps
module gpio_edge_port_bench;
   localparam int LIMIT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  pad_in = '0;
   logic [7:0]  pad_out, pad_oe;
   logic [31:0] alt_out = 32'hC3A5_5A3C;
   logic [31:0] alt_oe  = 32'h0FF0_F00F;
   logic        irq;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 0;

   always #2.5 clk = ~clk;

   gpio_edge_port u_gpio_edge_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
      .irq(irq)
   );

   // behavioural reference state
   logic [7:0]  m_s1, m_s2, m_fout, m_prev, m_flags;
   logic [7:0]  m_dout, m_dir, m_edge, m_ie, m_fen, m_mode;
   logic [15:0] m_fsel;
   int          m_cnt [8];

   function automatic logic [7:0] m_lvl();
      return (m_fen & m_fout) | (~m_fen & m_s2);
   endfunction

   function automatic logic [15:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {8'h00, m_dout};
         3'd1: return {8'h00, m_dir};
         3'd2: return {m_edge, m_ie};
         3'd3: return {8'h00, m_fen};
         3'd4: return {8'h00, m_mode};
         3'd5: return m_fsel;
         3'd6: return {8'h00, m_flags};
         default: return {8'h00, m_lvl()};
      endcase
   endfunction

   function automatic logic [7:0] m_pad(input bit want_oe);
      logic [7:0] r;
      for (int n = 0; n < 8; n++) begin
         int f;
         f = int'(m_fsel[2*n +: 2]);
         if (m_mode[n]) r[n] = want_oe ? alt_oe[f*8+n] : alt_out[f*8+n];
         else           r[n] = want_oe ? m_dir[n] : m_dout[n];
      end
      return r;
   endfunction

   task automatic model_reset();
      m_s1 = '0; m_s2 = '0; m_fout = '0; m_prev = '0; m_flags = '0;
      m_dout = '0; m_dir = '0; m_edge = '0; m_ie = '0; m_fen = '0;
      m_mode = '0; m_fsel = '0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
   endtask

   task automatic model_step();
      logic [7:0] lvl, evt, clr;
      lvl = m_lvl();
      evt = (m_edge & ~lvl & m_prev) | (~m_edge & lvl & ~m_prev);
      clr = (bus_wr && bus_addr == 3'd6) ? bus_wdata[7:0] : 8'h00;
      m_flags = (m_flags & ~clr) | evt;
      m_prev = lvl;
      for (int i = 0; i < 8; i++) begin
         if (m_s2[i] == m_fout[i]) m_cnt[i] = 0;
         else if (m_cnt[i] == LIMIT - 1) begin
            m_fout[i] = m_s2[i];
            m_cnt[i] = 0;
         end else m_cnt[i]++;
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (bus_wr) begin
         case (bus_addr)
            3'd0: m_dout = bus_wdata[7:0];
            3'd1: m_dir  = bus_wdata[7:0];
            3'd2: begin m_edge = bus_wdata[15:8]; m_ie = bus_wdata[7:0]; end
            3'd3: m_fen  = bus_wdata[7:0];
            3'd4: m_mode = bus_wdata[7:0];
            3'd5: m_fsel = bus_wdata;
            default: ;
         endcase
      end
   endtask

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else        model_step();
      #2;
      if (rst_n && !done) begin
         chk(bus_rdata == m_read(bus_addr), "R2 read data", bus_rdata, m_read(bus_addr));
         chk(pad_out == m_pad(1'b0), "R8/R9 pad_out", {8'h0, pad_out}, {8'h0, m_pad(1'b0)});
         chk(pad_oe == m_pad(1'b1), "R8/R9 pad_oe", {8'h0, pad_oe}, {8'h0, m_pad(1'b1)});
         chk(irq == |(m_flags & m_ie), "R7 irq", {15'h0, irq}, {15'h0, |(m_flags & m_ie)});
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic set_pad(input logic [7:0] v);
      @(negedge clk);
      pad_in = v;
   endtask

   task automatic rd_expect(input logic [2:0] a, input logic [15:0] e, input string tag);
      @(negedge clk);
      bus_addr = a;
      #0.5;
      chk(bus_rdata == e, tag, bus_rdata, e);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] fs;
      logic [7:0]  ex_o, ex_e;
      idle(3);
      rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 8; a++) rd_expect(3'(a), 16'h0000, "R1 reset register");
      chk(pad_out == 8'h00 && pad_oe == 8'h00, "R1 pads", {pad_out, pad_oe}, 16'h0);
      chk(irq == 1'b0, "R1 irq", {15'h0, irq}, 16'h0);

      // R2: field layout and reserved bits
      wr(3'd3, 16'hFFFF);
      rd_expect(3'd3, 16'h00FF, "R2 filter reg reserved bits");
      wr(3'd3, 16'h0000);
      wr(3'd2, 16'hA55A);
      rd_expect(3'd2, 16'hA55A, "R2 edge/enable reg");
      wr(3'd2, 16'h0000);

      // R8: GPIO routing
      wr(3'd0, 16'h005A);
      wr(3'd1, 16'h00F0);
      idle(1);
      chk(pad_out == 8'h5A && pad_oe == 8'hF0, "R8 gpio pads", {pad_out, pad_oe}, 16'h5AF0);

      // R9: mixed per-pin selectors, then uniform selector
      fs = '0;
      for (int n = 0; n < 8; n++) fs[2*n +: 2] = 2'(n % 4);
      wr(3'd5, fs);
      wr(3'd4, 16'h00FF);
      idle(1);
      for (int n = 0; n < 8; n++) begin
         ex_o[n] = alt_out[(n % 4)*8 + n];
         ex_e[n] = alt_oe[(n % 4)*8 + n];
      end
      chk(pad_out == ex_o && pad_oe == ex_e, "R9 mixed selectors", {pad_out, pad_oe}, {ex_o, ex_e});
      wr(3'd5, 16'hFFFF);
      idle(1);
      chk(pad_out == alt_out[31:24] && pad_oe == alt_oe[31:24], "R9 function 3",
          {pad_out, pad_oe}, {alt_out[31:24], alt_oe[31:24]});
      wr(3'd4, 16'h0000);

      // R4: synchroniser latency, bypass path
      bus_addr = 3'd7;
      set_pad(8'h01);
      rd_expect(3'd7, 16'h0000, "R4 level after one edge");
      rd_expect(3'd7, 16'h0001, "R4 level after two edges");
      // R3: rising flag set while enable is off
      rd_expect(3'd6, 16'h0001, "R3 rising flag without enable");
      chk(irq == 1'b0, "R7 flag alone gives no irq", {15'h0, irq}, 16'h0);
      wr(3'd2, 16'h0001);
      #0.5;
      chk(irq == 1'b1, "R7 irq after enable", {15'h0, irq}, 16'h1);
      wr(3'd6, 16'h0001);
      #0.5;
      chk(irq == 1'b0, "R6 clear drops irq", {15'h0, irq}, 16'h0);
      rd_expect(3'd6, 16'h0000, "R6 flag cleared");

      // R3: falling polarity on pin 1
      wr(3'd2, 16'h0201);
      set_pad(8'h03);
      idle(4);
      rd_expect(3'd6, 16'h0000, "R3 rise ignored on falling select");
      set_pad(8'h01);
      idle(4);
      rd_expect(3'd6, 16'h0002, "R3 falling flag");
      wr(3'd6, 16'h0000);
      rd_expect(3'd6, 16'h0002, "R6 writing zero keeps flag");
      wr(3'd6, 16'h00FF);

      // R5: filter limits on pins 2 and 3
      wr(3'd3, 16'h000C);
      set_pad(8'h05);
      idle(2);
      set_pad(8'h01);
      idle(6);
      rd_expect(3'd6, 16'h0000, "R5 three-cycle pulse no flag");
      rd_expect(3'd7, 16'h0001, "R5 three-cycle pulse no level");
      set_pad(8'h09);
      idle(3);
      set_pad(8'h01);
      idle(8);
      rd_expect(3'd6, 16'h0008, "R5 four-cycle pulse accepted");
      rd_expect(3'd7, 16'h0001, "R5 level returns low");
      set_pad(8'h05);
      idle(10);
      rd_expect(3'd7, 16'h0005, "R5 long hold level");
      rd_expect(3'd6, 16'h000C, "R5 long hold flag");
      wr(3'd6, 16'h00FF);
      wr(3'd3, 16'h0000);

      // R6: set wins over a clear in the same cycle (pin 4, bypass)
      set_pad(8'h15);
      idle(1);
      wr(3'd6, 16'h0010);
      rd_expect(3'd6, 16'h0010, "R6 set wins over clear");
      wr(3'd6, 16'h00FF);
      rd_expect(3'd6, 16'h0000, "R6 final clear");

      idle(2);
      done = 1;
      summary();
      $finish;
   end
endmodule